// File: doc/BRIEF.md
# Dual-Loop Synthesizer Serial Configuration Register

This block receives configuration for a two-loop frequency synthesizer over a three-wire serial link: a data line, a bit clock and a load strobe. The three wires are slow and asynchronous to the chip clock. The block brings each wire into the `clk` domain through a short synchronizer and acts on the rising edges it detects there.

Each rising edge of the serial clock moves one data bit into a 22-bit shift register, most significant bit first. A rising edge of the load strobe then decodes the two control bits that arrived last. These bits pick one of four holding registers, and only that register takes a copy of the word. The four holding registers are:

- the reference/configuration set of the high-band loop,
- the reference/configuration set of the low-band loop,
- the counter set of the high-band loop,
- the counter set of the low-band loop.

Each kind of register lays the remaining 20 bits out in its own way. The holding registers drive the divider and charge-pump logic through flat output fields.

Top module: `pll_serial_cfg`

## Requirements
- R1: One data bit enters the shift register per rising edge of `ser_clk_i`, most significant bit first. A serial clock that stays high, or that falls, shifts nothing.
- R2: Word bit 0 is the last bit shifted in and bit 1 is the one before it. On a load, bit 0 selects the loop (1 = high band, 0 = low band). Bit 1 selects the kind of set (1 = counter set, 0 = reference set).
- R3: A load with bits[1:0] = 00 sets the low-band reference set as follows: divider = bits[16:2] (bit 2 is its LSB), polarity = bit 17, high current = bit 18, tri-state = bit 19, lock-output select = bit 20, divider-output select = bit 21.
- R4: A load with bits[1:0] = 01 sets the high-band reference set, using the same field positions as R3.
- R5: A load with bits[1:0] = 10 sets the low-band counter set as follows: swallow = bits[5:2], main = bits[19:9], prescaler select = bit 20, power-down = bit 21. Bits[8:6] are ignored.
- R6: A load with bits[1:0] = 11 sets the high-band counter set as follows: swallow = bits[8:2], main = bits[19:9], prescaler select = bit 20, power-down = bit 21.
- R7: A load changes only the set it selects. The other three sets keep their values.
- R8: Shifting does not change any output. The outputs change only on a load.
- R9: A set whose power-down bit is 1 still accepts and applies later loads.
- R10: Reset clears every output field to 0.
- R11: When more than 22 bits are shifted in before a load, only the last 22 are used.
- R12: The outputs show a load within 4 `clk` cycles of the rising edge of the load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock; samples the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_data_i | input | 1 | Serial data |
| ser_le_i | input | 1 | Load strobe; a rising edge loads the word |
| ref_div_hi_o | output | 15 | High-band reference divider |
| pol_hi_o | output | 1 | High-band phase-detector polarity |
| cp_cur_hi_o | output | 1 | High-band charge-pump high current |
| cp_tri_hi_o | output | 1 | High-band charge-pump tri-state |
| lock_sel_hi_o | output | 1 | High-band lock-output select |
| fout_sel_hi_o | output | 1 | High-band divider-output select |
| ref_div_lo_o | output | 15 | Low-band reference divider |
| pol_lo_o | output | 1 | Low-band phase-detector polarity |
| cp_cur_lo_o | output | 1 | Low-band charge-pump high current |
| cp_tri_lo_o | output | 1 | Low-band charge-pump tri-state |
| lock_sel_lo_o | output | 1 | Low-band lock-output select |
| fout_sel_lo_o | output | 1 | Low-band divider-output select |
| swal_hi_o | output | 7 | High-band swallow count |
| main_hi_o | output | 11 | High-band main count |
| pre_hi_o | output | 1 | High-band prescaler select |
| pwrdn_hi_o | output | 1 | High-band power-down |
| swal_lo_o | output | 4 | Low-band swallow count |
| main_lo_o | output | 11 | Low-band main count |
| pre_lo_o | output | 1 | Low-band prescaler select |
| pwrdn_lo_o | output | 1 | Low-band power-down |

## Verification
The assertions assume the following about the serial wires:

- Each wire holds every level for several `clk` cycles. This makes each detected edge one clean pulse.
- A serial-clock edge and a load edge never reach the synchronizer outputs in the same cycle.
- Data is stable when its serial-clock edge is sampled.

The stimulus keeps every phase of the data, serial clock and load strobe at 16 `clk` cycles, which is well above the 50 ns minimum interval of the link. It changes data only while the serial clock is low. After the last bit it leaves the serial clock high, so that the pulse on the load strobe is seen on its own.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CTRL_W  = 2;
  localparam int R_W     = 15;
  localparam int FLAGS_W = 5;
  localparam int AH_W    = 7;
  localparam int AL_W    = 4;
  localparam int B_W     = 11;
  localparam int WORD_W  = CTRL_W + R_W + FLAGS_W;
  localparam int LOOP_POS = 0;
  localparam int KIND_POS = 1;
  localparam int BODY_LSB = CTRL_W;
  localparam int FLAG_LSB = BODY_LSB + R_W;
  localparam int B_LSB    = BODY_LSB + AH_W;
  localparam int PRE_POS  = B_LSB + B_W;
  localparam int PD_POS   = PRE_POS + 1;

  typedef struct packed {
    logic [R_W-1:0] div;
    logic           pol;
    logic           cur;
    logic           tri_st;
    logic           lock_sel;
    logic           fout_sel;
  } ref_set_t;

  typedef struct packed {
    logic [AH_W-1:0] swal;
    logic [B_W-1:0]  main;
    logic            pre;
    logic            pd;
  } cnt_hi_t;

  typedef struct packed {
    logic [AL_W-1:0] swal;
    logic [B_W-1:0]  main;
    logic            pre;
    logic            pd;
  } cnt_lo_t;

  function automatic logic is_cnt(input logic [WORD_W-1:0] w);
    return w[KIND_POS];
  endfunction

  function automatic logic is_hi(input logic [WORD_W-1:0] w);
    return w[LOOP_POS];
  endfunction

  function automatic ref_set_t ref_of(input logic [WORD_W-1:0] w);
    ref_set_t r;
    r.div      = w[BODY_LSB +: R_W];
    r.pol      = w[FLAG_LSB];
    r.cur      = w[FLAG_LSB+1];
    r.tri_st   = w[FLAG_LSB+2];
    r.lock_sel = w[FLAG_LSB+3];
    r.fout_sel = w[FLAG_LSB+4];
    return r;
  endfunction

  function automatic cnt_hi_t cnt_hi_of(input logic [WORD_W-1:0] w);
    cnt_hi_t c;
    c.swal = w[BODY_LSB +: AH_W];
    c.main = w[B_LSB +: B_W];
    c.pre  = w[PRE_POS];
    c.pd   = w[PD_POS];
    return c;
  endfunction

  function automatic cnt_lo_t cnt_lo_of(input logic [WORD_W-1:0] w);
    cnt_lo_t c;
    c.swal = w[BODY_LSB +: AL_W];
    c.main = w[B_LSB +: B_W];
    c.pre  = w[PRE_POS];
    c.pd   = w[PD_POS];
    return c;
  endfunction
endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output ref_set_t [1:0]    ref_o,
  output cnt_hi_t           cnt_hi_o,
  output cnt_lo_t           cnt_lo_o
);
  localparam int LOOPS = 2;

  for (genvar g = 0; g < LOOPS; g++) begin : g_ref
    logic hit;
    assign hit = load_i && !is_cnt(word_i) && (is_hi(word_i) == (g == 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ref_o[g] <= '0;
      else if (hit) ref_o[g] <= ref_of(word_i);
    end
  end

  logic hit_cnt_hi, hit_cnt_lo;
  assign hit_cnt_hi = load_i && is_cnt(word_i) && is_hi(word_i);
  assign hit_cnt_lo = load_i && is_cnt(word_i) && !is_hi(word_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_hi_o <= '0;
      cnt_lo_o <= '0;
    end else begin
      if (hit_cnt_hi) cnt_hi_o <= cnt_hi_of(word_i);
      if (hit_cnt_lo) cnt_lo_o <= cnt_lo_of(word_i);
    end
  end
endmodule

// File: rtl/pll_serial_cfg.sv
module pll_serial_cfg
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_clk_i,
  input  logic            ser_data_i,
  input  logic            ser_le_i,
  output logic [R_W-1:0]  ref_div_hi_o,
  output logic            pol_hi_o,
  output logic            cp_cur_hi_o,
  output logic            cp_tri_hi_o,
  output logic            lock_sel_hi_o,
  output logic            fout_sel_hi_o,
  output logic [R_W-1:0]  ref_div_lo_o,
  output logic            pol_lo_o,
  output logic            cp_cur_lo_o,
  output logic            cp_tri_lo_o,
  output logic            lock_sel_lo_o,
  output logic            fout_sel_lo_o,
  output logic [AH_W-1:0] swal_hi_o,
  output logic [B_W-1:0]  main_hi_o,
  output logic            pre_hi_o,
  output logic            pwrdn_hi_o,
  output logic [AL_W-1:0] swal_lo_o,
  output logic [B_W-1:0]  main_lo_o,
  output logic            pre_lo_o,
  output logic            pwrdn_lo_o
);
  // Named internal events for the checker
  logic              shift_evt, load_evt, data_lvl;
  logic              clk_lvl, le_lvl, data_rise;
  logic [WORD_W-1:0] word_q;
  ref_set_t [1:0]    ref_q;
  cnt_hi_t           cnt_hi_q;
  cnt_lo_t           cnt_lo_q;

  cfg_in_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d_i(ser_clk_i), .lvl_o(clk_lvl), .rise_o(shift_evt));
  cfg_in_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d_i(ser_data_i), .lvl_o(data_lvl), .rise_o(data_rise));
  cfg_in_sync #(.STAGES(SYNC_STAGES)) u_sync_le (
    .clk(clk), .rst_n(rst_n), .d_i(ser_le_i), .lvl_o(le_lvl), .rise_o(load_evt));

  cfg_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_i(shift_evt), .bit_i(data_lvl), .word_o(word_q));

  cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .word_i(word_q),
    .ref_o(ref_q), .cnt_hi_o(cnt_hi_q), .cnt_lo_o(cnt_lo_q));

  assign ref_div_hi_o  = ref_q[1].div;
  assign pol_hi_o      = ref_q[1].pol;
  assign cp_cur_hi_o   = ref_q[1].cur;
  assign cp_tri_hi_o   = ref_q[1].tri_st;
  assign lock_sel_hi_o = ref_q[1].lock_sel;
  assign fout_sel_hi_o = ref_q[1].fout_sel;
  assign ref_div_lo_o  = ref_q[0].div;
  assign pol_lo_o      = ref_q[0].pol;
  assign cp_cur_lo_o   = ref_q[0].cur;
  assign cp_tri_lo_o   = ref_q[0].tri_st;
  assign lock_sel_lo_o = ref_q[0].lock_sel;
  assign fout_sel_lo_o = ref_q[0].fout_sel;
  assign swal_hi_o     = cnt_hi_q.swal;
  assign main_hi_o     = cnt_hi_q.main;
  assign pre_hi_o      = cnt_hi_q.pre;
  assign pwrdn_hi_o    = cnt_hi_q.pd;
  assign swal_lo_o     = cnt_lo_q.swal;
  assign main_lo_o     = cnt_lo_q.main;
  assign pre_lo_o      = cnt_lo_q.pre;
  assign pwrdn_lo_o    = cnt_lo_q.pd;

  // Levels kept visible for debug; tie-off keeps them referenced
  logic unused_lvls;
  assign unused_lvls = clk_lvl ^ le_lvl ^ data_rise;
endmodule

// File: rtl/pll_serial_cfg_chk.sv
module pll_serial_cfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        shift_evt,
  input logic        load_evt,
  input logic        data_lvl,
  input logic [21:0] word_q,
  input logic [19:0] ref_hi,
  input logic [19:0] ref_lo,
  input logic [19:0] cnt_hi,
  input logic [16:0] cnt_lo
);
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> word_q[0] == $past(data_lvl)); // R1

  AST_REF_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && word_q[1:0] == 2'b00) |=>
      ref_lo == {$past(word_q[16:2]), $past(word_q[17]), $past(word_q[18]),
                 $past(word_q[19]), $past(word_q[20]), $past(word_q[21])}); // R3

  AST_CNT_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && word_q[1:0] == 2'b10) |=>
      cnt_lo == {$past(word_q[5:2]), $past(word_q[19:9]), $past(word_q[20]),
                 $past(word_q[21])}); // R5

  AST_HI_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !word_q[0]) |=> ($stable(ref_hi) && $stable(cnt_hi))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(ref_hi) && $stable(ref_lo) && $stable(cnt_hi) &&
                   $stable(cnt_lo))); // R8
endmodule

bind pll_serial_cfg pll_serial_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shift_evt(shift_evt), .load_evt(load_evt),
  .data_lvl(data_lvl), .word_q(word_q),
  .ref_hi({ref_div_hi_o, pol_hi_o, cp_cur_hi_o, cp_tri_hi_o, lock_sel_hi_o, fout_sel_hi_o}),
  .ref_lo({ref_div_lo_o, pol_lo_o, cp_cur_lo_o, cp_tri_lo_o, lock_sel_lo_o, fout_sel_lo_o}),
  .cnt_hi({swal_hi_o, main_hi_o, pre_hi_o, pwrdn_hi_o}),
  .cnt_lo({swal_lo_o, main_lo_o, pre_lo_o, pwrdn_lo_o}));

// File: tb/pll_serial_cfg_tb.sv
`timescale 1ns/1ps
module pll_serial_cfg_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [14:0] rdh, rdl;
  logic ph, ch, th, lh, fh, pl, cl, tl, ll, fl;
  logic [6:0] sh;
  logic [3:0] sl;
  logic [10:0] mh, ml;
  logic prh, pdh, prl, pdl;

  always #2 clk = ~clk;

  pll_serial_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_le_i(ser_le),
    .ref_div_hi_o(rdh), .pol_hi_o(ph), .cp_cur_hi_o(ch), .cp_tri_hi_o(th),
    .lock_sel_hi_o(lh), .fout_sel_hi_o(fh),
    .ref_div_lo_o(rdl), .pol_lo_o(pl), .cp_cur_lo_o(cl), .cp_tri_lo_o(tl),
    .lock_sel_lo_o(ll), .fout_sel_lo_o(fl),
    .swal_hi_o(sh), .main_hi_o(mh), .pre_hi_o(prh), .pwrdn_hi_o(pdh),
    .swal_lo_o(sl), .main_lo_o(ml), .pre_lo_o(prl), .pwrdn_lo_o(pdl));

  int checks = 0, errors = 0;
  bit done = 0;
  // Snapshot layout: [76:57] ref lo, [56:37] ref hi, [36:20] cnt lo, [19:0] cnt hi
  logic [76:0] model = '0;
  logic [76:0] exp_q[$];
  string       tag_q[$];
  event        sample_ev;

  function automatic logic [76:0] observe();
    return {rdl, pl, cl, tl, ll, fl, rdh, ph, ch, th, lh, fh,
            sl, ml, prl, pdl, sh, mh, prh, pdh};
  endfunction

  // Word builders: bit0 = loop (1 high), bit1 = kind (1 counter)
  function automatic logic [21:0] mk_ref(bit hi, logic [14:0] r, bit fc, bit ido, bit ts, bit ld, bit fo);
    return {fo, ld, ts, ido, fc, r, 1'b0, hi};
  endfunction
  function automatic logic [21:0] mk_cnt(bit hi, logic [6:0] a, logic [10:0] b, bit pre, bit pd);
    return {pd, pre, b, a, 1'b1, hi};
  endfunction

  // Independent model of a load
  task automatic model_load(input logic [21:0] w);
    logic [19:0] rf;
    rf = {w[16:2], w[17], w[18], w[19], w[20], w[21]};
    case ({w[1], w[0]})
      2'b00: model[76:57] = rf;
      2'b01: model[56:37] = rf;
      2'b10: model[36:20] = {w[5:2], w[19:9], w[20], w[21]};
      default: model[19:0] = {w[8:2], w[19:9], w[20], w[21]};
    endcase
  endtask

  task automatic expect_now(input string tag);
    exp_q.push_back(model);
    tag_q.push_back(tag);
    -> sample_ev;
    #0;
  endtask

  // Monitor: pops expected snapshots and compares the four sets
  initial begin
    forever begin
      logic [76:0] a, e;
      string t;
      @(sample_ev);
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = observe();
        checks += 4;
        if (a[76:57] !== e[76:57]) begin errors++; $display("FAIL %s ref_lo act=%h exp=%h", t, a[76:57], e[76:57]); end
        if (a[56:37] !== e[56:37]) begin errors++; $display("FAIL %s ref_hi act=%h exp=%h", t, a[56:37], e[56:37]); end
        if (a[36:20] !== e[36:20]) begin errors++; $display("FAIL %s cnt_lo act=%h exp=%h", t, a[36:20], e[36:20]); end
        if (a[19:0]  !== e[19:0])  begin errors++; $display("FAIL %s cnt_hi act=%h exp=%h", t, a[19:0], e[19:0]); end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shifts n bits, MSB first; the serial clock is left high at the end
  task automatic shift_bits(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_clk = 1'b0; ser_data = bits[i];
      wait_clk(16);
      ser_clk = 1'b1;
      wait_clk(16);
    end
  endtask

  task automatic load_pulse(input logic [21:0] w, input string tag);
    ser_le = 1'b1;
    wait_clk(4);                // R12: result must be visible 4 cycles after the edge
    model_load(w);
    expect_now({tag, " R12"});
    wait_clk(12);
    ser_le = 1'b0;
    wait_clk(16);
  endtask

  task automatic send(input logic [21:0] w, input string tag);
    shift_bits({42'd0, w}, 22);
    expect_now("R8 shift-only hold"); // nothing loaded yet
    load_pulse(w, tag);
    expect_now({tag, " R7 others held, R1 clock left high"});
  endtask

  initial begin
    wait_clk(5);
    expect_now("R10 reset state");
    rst_n = 1'b1;
    wait_clk(5);
    send(mk_ref(1'b0, 15'h1234, 1, 0, 1, 0, 1), "R3 R2 ref lo");
    send(mk_ref(1'b1, 15'h7FFF, 0, 1, 0, 1, 1), "R4 ref hi all-ones div");
    send(mk_cnt(1'b0, 7'h7F, 11'h5A3, 1, 0), "R5 cnt lo upper swallow ignored");
    send(mk_cnt(1'b1, 7'h55, 11'h7FF, 0, 1), "R6 cnt hi with power-down");
    send(mk_cnt(1'b0, 7'h06, 11'h003, 0, 1), "R5 cnt lo min main, power-down");
    send(mk_ref(1'b0, 15'h0003, 0, 1, 0, 1, 0), "R9 ref lo while powered down");
    send(mk_cnt(1'b1, 7'h2A, 11'h404, 1, 1), "R9 cnt hi reload while powered down");
    send(mk_ref(1'b1, 15'h0000, 1, 0, 0, 0, 0), "R4 ref hi zero div");
    // R11: 8 junk bits ahead of a valid word
    shift_bits({34'd0, 8'hA5, mk_cnt(1'b0, 7'h09, 11'h2C1, 1, 0)}, 30);
    expect_now("R11 R8 long stream hold");
    load_pulse(mk_cnt(1'b0, 7'h09, 11'h2C1, 1, 0), "R11 last 22 bits used");
    // R1: a second load strobe with no new shifts reloads the same word
    load_pulse(mk_cnt(1'b0, 7'h09, 11'h2C1, 1, 0), "R1 no shift without clock edge");
    // R10: reset again clears everything
    rst_n = 1'b0;
    wait_clk(3);
    model = '0;
    expect_now("R10 reset after loads");
    rst_n = 1'b1;
    wait_clk(4);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule